// File: doc/BRIEF.md
# Dual-Compare Timer PWM Generator

This block is a 16-bit timer that turns two compare values into a pulse-width-modulated output. The counter advances once per timer tick. A tick comes from the system clock divided by 2, 4 or 8, or from rising edges of an external clock after synchronization. While PWM operation is active, the first compare value marks the pulse edge and the second marks the period end. Each compare event drives its own programmable level onto the single output pin.

A period-end event restarts the counter at 16'hFFFC rather than at zero. One period therefore spans the end compare value plus five ticks. The same event sets a sticky cycle flag, which a separate strobe clears. When PWM operation is inactive, the counter runs freely and wraps, and the output pin keeps its last level. Software sets a compare value to the target time multiplied by the tick rate, minus five.

Top module: `pwm_dual_cmp_timer`

## Requirements
- R1: While reset is asserted, count_o is 16'hFFFC, pwm_o is 0 and cycle_flag_o is 0.
- R2: clk_sel_i selects the tick source: 2'b00, 2'b01 and 2'b10 give one count every 2, 4 and 8 system clocks. 2'b11 gives one count per rising edge of ext_clk_i after a two-flop synchronizer.
- R3: When PWM is not active, each tick adds one to the counter, and 16'hFFFF wraps to 16'h0000. pwm_o holds its level and cycle_flag_o is not set.
- R4: PWM is active only when pwm_en_i and pin_en_i are both 1. If either is 0, compare matches have no effect on pwm_o or cycle_flag_o.
- R5: On a tick while PWM is active and count_o equals cmp_edge_i, pwm_o takes the value of lvl_edge_i.
- R6: On a tick while PWM is active and count_o equals cmp_end_i, the counter loads 16'hFFFC, pwm_o takes lvl_end_i and cycle_flag_o is set.
- R7: With lvl_edge_i=1 and lvl_end_i=0, a PWM period lasts cmp_end_i+5 ticks. The high time is (cmp_end_i - cmp_edge_i) mod 2^16 ticks.
- R8: With lvl_edge_i equal to lvl_end_i, pwm_o settles at that level and never changes after that.
- R9: When both compare values match on the same tick, the end level lvl_end_i wins.
- R10: cycle_flag_o stays set until flag_clr_i is 1. A set and a clear in the same cycle leave the flag set.
- R11: The compare inputs may change at any time. A new value takes effect at the next count that matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External timer clock, asynchronous |
| clk_sel_i | input | 2 | Tick source select |
| pwm_en_i | input | 1 | PWM mode enable |
| pin_en_i | input | 1 | Output pin dedicated to compare logic |
| lvl_edge_i | input | 1 | Level driven on an edge compare match |
| lvl_end_i | input | 1 | Level driven on a period-end match |
| cmp_edge_i | input | 16 | Pulse edge compare value |
| cmp_end_i | input | 16 | Period end compare value |
| flag_clr_i | input | 1 | Cycle flag clear strobe |
| pwm_o | output | 1 | PWM output pin |
| cycle_flag_o | output | 1 | Sticky end-of-cycle flag |
| count_o | output | 16 | Current counter value |

## Verification
A wrong tick divisor, a wrong reload value or a missed end match changes the measured period or high time of pwm_o within the first full period after reset. That is at most 14 ticks for the values swept here. A wrong match priority or a wrong level choice shows as a stuck or inverted pin within one period. A broken enable gate shows as a pin or flag that moves while it should hold. A wrong count step or a missing wrap shows in count_o at the very next tick, because the bench follows every counter change.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    CS_DIV2 = 2'b00,
    CS_DIV4 = 2'b01,
    CS_DIV8 = 2'b10,
    CS_EXT  = 2'b11
  } clk_sel_e;

  // Number of low prescaler bits that must be all ones for an internal tick.
  function automatic int unsigned tick_bits(input logic [1:0] sel);
    case (sel)
      CS_DIV2: return 1;
      CS_DIV4: return 2;
      default: return 3;
    endcase
  endfunction

  // Pin level after a tick: the period-end match has priority.
  function automatic logic next_level(input logic cur, input logic edge_ev,
                                      input logic end_ev, input logic lvl_edge,
                                      input logic lvl_end);
    if (end_ev)  return lvl_end;
    if (edge_ev) return lvl_edge;
    return cur;
  endfunction

  // Sticky flag update: a set wins over a clear in the same cycle.
  function automatic logic next_flag(input logic cur, input logic set_ev,
                                     input logic clr);
    if (set_ev) return 1'b1;
    if (clr)    return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/pwmt_tick_gen.sv
module pwmt_tick_gen
  import pwmt_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk_i,
  input  logic [1:0] clk_sel_i,
  output logic       tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [SYNC_N:0]  sync_q;
  logic [PRE_W-1:0] need_mask;
  logic             int_tick;
  logic             ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // SYNC_N synchronizer stages plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], ext_clk_i};
  end

  always_comb begin
    need_mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      need_mask[i] = (i < tick_bits(clk_sel_i));
    end
  end

  assign int_tick = &(pre_q | ~need_mask);
  assign ext_rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign tick_o   = (clk_sel_e'(clk_sel_i) == CS_EXT) ? ext_rise : int_tick;

endmodule

// File: rtl/pwmt_match.sv
module pwmt_match #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic [W-1:0]        count_i,
  input  logic [N-1:0][W-1:0] cmp_i,
  output logic [N-1:0]        hit_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = (count_i == cmp_i[g]);
  end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int          W      = 16,
  parameter logic [W-1:0] RELOAD = 16'hFFFC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         reload_i,
  output logic [W-1:0] count_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= RELOAD;
    else if (tick_i) count_o <= reload_i ? RELOAD : count_o + 1'b1;
  end

endmodule

// File: rtl/pwmt_out_ctl.sv
module pwmt_out_ctl
  import pwmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_ev_i,
  input  logic end_ev_i,
  input  logic lvl_edge_i,
  input  logic lvl_end_i,
  input  logic flag_clr_i,
  output logic pin_o,
  output logic flag_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      pin_o  <= next_level(pin_o, edge_ev_i, end_ev_i, lvl_edge_i, lvl_end_i);
      flag_o <= next_flag(flag_o, end_ev_i, flag_clr_i);
    end
  end

endmodule

// File: rtl/pwm_dual_cmp_timer.sv
module pwm_dual_cmp_timer #(
  parameter int              CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_VAL = 16'hFFFC,
  parameter int              PRE_W      = 3,
  parameter int              SYNC_N     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             pwm_en_i,
  input  logic             pin_en_i,
  input  logic             lvl_edge_i,
  input  logic             lvl_end_i,
  input  logic [CNT_W-1:0] cmp_edge_i,
  input  logic [CNT_W-1:0] cmp_end_i,
  input  logic             flag_clr_i,
  output logic             pwm_o,
  output logic             cycle_flag_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int N_CMP   = 2;
  localparam int IDX_EDG = 0;
  localparam int IDX_END = 1;

  // Named internal events, visible to the bound checker.
  logic                        tick;
  logic                        pwm_act;
  logic                        edge_hit;
  logic                        end_hit;
  logic                        edge_ev;
  logic                        end_ev;
  logic [N_CMP-1:0]            hits;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_vec;

  assign pwm_act = pwm_en_i & pin_en_i;

  assign cmp_vec[IDX_EDG] = cmp_edge_i;
  assign cmp_vec[IDX_END] = cmp_end_i;

  pwmt_tick_gen #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk_i (ext_clk_i),
    .clk_sel_i (clk_sel_i),
    .tick_o    (tick)
  );

  pwmt_match #(.W(CNT_W), .N(N_CMP)) u_match (
    .count_i (count_o),
    .cmp_i   (cmp_vec),
    .hit_o   (hits)
  );

  assign edge_hit = hits[IDX_EDG];
  assign end_hit  = hits[IDX_END];
  assign edge_ev  = tick & pwm_act & edge_hit;
  assign end_ev   = tick & pwm_act & end_hit;

  pwmt_counter #(.W(CNT_W), .RELOAD(RELOAD_VAL)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .reload_i (end_ev),
    .count_o  (count_o)
  );

  pwmt_out_ctl u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_ev_i  (edge_ev),
    .end_ev_i   (end_ev),
    .lvl_edge_i (lvl_edge_i),
    .lvl_end_i  (lvl_end_i),
    .flag_clr_i (flag_clr_i),
    .pin_o      (pwm_o),
    .flag_o     (cycle_flag_o)
  );

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
  parameter int          W      = 16,
  parameter logic [W-1:0] RELOAD = 16'hFFFC
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         pwm_act,
  input logic         edge_hit,
  input logic         end_hit,
  input logic         lvl_edge,
  input logic         lvl_end,
  input logic         flag_clr,
  input logic [W-1:0] count,
  input logic         pin,
  input logic         flag
);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (count == RELOAD) && !pin && !flag);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !(pwm_act && end_hit) |=> count == $past(count) + 1'b1);

  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && pwm_act && (edge_hit || end_hit)) |=> $stable(pin));

  a_r5_edge_level: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pwm_act && edge_hit && !end_hit |=> pin == $past(lvl_edge));

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pwm_act && end_hit |=> (count == RELOAD) && flag && (pin == $past(lvl_end)));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !(tick && pwm_act && end_hit) |=> !flag);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);

endmodule

bind pwm_dual_cmp_timer pwmt_checker #(.W(CNT_W), .RELOAD(RELOAD_VAL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .pwm_act  (pwm_act),
  .edge_hit (edge_hit),
  .end_hit  (end_hit),
  .lvl_edge (lvl_edge_i),
  .lvl_end  (lvl_end_i),
  .flag_clr (flag_clr_i),
  .count    (count_o),
  .pin      (pwm_o),
  .flag     (cycle_flag_o)
);

// File: tb/tb_pwm_dual_cmp_timer.sv
module tb_pwm_dual_cmp_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic [1:0]  clk_sel = 2'b00;
  logic        pwm_en = 1'b0;
  logic        pin_en = 1'b0;
  logic        lvl_edge = 1'b0;
  logic        lvl_end = 1'b0;
  logic [15:0] cmp_edge = 16'd0;
  logic [15:0] cmp_end = 16'd0;
  logic        flag_clr = 1'b0;
  logic        pwm_o;
  logic        cycle_flag_o;
  logic [15:0] count_o;

  int vecs = 0;
  int errs = 0;
  int ext_half = 0;
  int ends[3] = '{2, 5, 9};

  always #10ns clk = ~clk;

  always begin
    if (ext_half == 0) begin
      ext_clk = 1'b0;
      @(negedge clk);
    end else begin
      repeat (ext_half) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  pwm_dual_cmp_timer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_clk_i    (ext_clk),
    .clk_sel_i    (clk_sel),
    .pwm_en_i     (pwm_en),
    .pin_en_i     (pin_en),
    .lvl_edge_i   (lvl_edge),
    .lvl_end_i    (lvl_end),
    .cmp_edge_i   (cmp_edge),
    .cmp_end_i    (cmp_end),
    .flag_clr_i   (flag_clr),
    .pwm_o        (pwm_o),
    .cycle_flag_o (cycle_flag_o),
    .count_o      (count_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input logic [1:0] sel, input logic [15:0] e, input logic [15:0] p,
                       input logic le, input logic lp);
    clk_sel = sel; cmp_edge = e; cmp_end = p; lvl_edge = le; lvl_end = lp;
    pwm_en = 1'b1; pin_en = 1'b1;
  endtask

  // Clock counts of one high phase and one full period of pwm_o.
  task automatic measure(output int hi, output int per);
    logic prev, cur, rise;
    int n;
    n = 0; prev = pwm_o; rise = 1'b0;
    while (!rise && n < 20000) begin
      @(negedge clk); cur = pwm_o; rise = !prev && cur; prev = cur; n++;
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (!pwm_o || hi > 20000) break;
      hi++;
    end
    per = hi + 1;
    forever begin
      @(negedge clk);
      if (pwm_o || per > 40000) break;
      per++;
    end
  endtask

  // Counts rising and falling transitions of pwm_o over a window.
  task automatic watch_pin(input int cyc, output int rises, output int falls);
    logic prev;
    rises = 0; falls = 0; prev = pwm_o;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (!prev && pwm_o) rises++;
      if (prev && !pwm_o) falls++;
      prev = pwm_o;
    end
  endtask

  initial begin
    int hi, per, r, f, div, last, gap, steps, flag_seen;
    logic [15:0] old;

    // R1 reset state
    @(negedge clk);
    chk("R1 count", count_o, 16'hFFFC);
    chk("R1 pin", pwm_o, 0);
    chk("R1 flag", cycle_flag_o, 0);

    // R2, R7: sweep internal divisors, period ends and edges
    for (int d = 0; d < 3; d++) begin
      for (int k = 0; k < 3; k++) begin
        for (int e = 0; e < ends[k]; e++) begin
          setup(2'(d), 16'(e), 16'(ends[k]), 1'b1, 1'b0);
          do_reset();
          measure(hi, per);
          div = 2 << d;
          chk("R7 high", hi, (ends[k] - e) * div);
          chk("R2 R7 period", per, (ends[k] + 5) * div);
        end
      end
    end

    // R7 edge inside the reload region: high wraps modulo 2^16
    setup(2'b00, 16'hFFFE, 16'd5, 1'b1, 1'b0);
    do_reset();
    measure(hi, per);
    chk("R7 wrapped high", hi, 7 * 2);
    chk("R7 wrapped period", per, 10 * 2);

    // R2 external clock source
    for (int h = 2; h <= 5; h++) begin
      ext_half = h;
      setup(2'b11, 16'd2, 16'd5, 1'b1, 1'b0);
      do_reset();
      measure(hi, per);
      chk("R2 ext high", hi, 3 * 2 * h);
      chk("R2 ext period", per, 10 * 2 * h);
    end
    ext_half = 0;

    // R3 free run with divide by 4, including the wrap to zero
    setup(2'b01, 16'd1, 16'd1, 1'b1, 1'b1);
    pwm_en = 1'b0;
    do_reset();
    old = count_o; last = -1; gap = 0; steps = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      gap++;
      if (count_o != old) begin
        chk("R3 step", count_o, 16'(old + 16'd1));
        if (last >= 0) chk("R2 div4 spacing", gap, 4);
        last = 1; gap = 0; old = count_o; steps++;
      end
    end
    chk("R3 wrap reached", int'(steps >= 10 && count_o < 16'h0100), 1);
    chk("R3 pin held", pwm_o, 0);
    chk("R3 flag clear", cycle_flag_o, 0);

    // R4 pin enable off with PWM bit on
    setup(2'b00, 16'd1, 16'd3, 1'b1, 1'b1);
    pin_en = 1'b0;
    do_reset();
    watch_pin(60, r, f);
    chk("R4 pin_en off rises", r, 0);
    chk("R4 pin_en off flag", cycle_flag_o, 0);

    // R4 hold: output stays high after PWM is turned off mid-pulse
    setup(2'b00, 16'd2, 16'd9, 1'b1, 1'b0);
    do_reset();
    while (!pwm_o) @(negedge clk);
    pwm_en = 1'b0;
    watch_pin(100, r, f);
    chk("R4 held falls", f, 0);
    chk("R4 held level", pwm_o, 1);
    chk("R4 no flag when off", cycle_flag_o, 0);

    // R5 R6: reload value, flag and level at the end match
    setup(2'b00, 16'd1, 16'd4, 1'b1, 1'b0);
    do_reset();
    old = count_o; flag_seen = 0;
    for (int i = 0; i < 40 && flag_seen == 0; i++) begin
      @(negedge clk);
      if (count_o != old && count_o != 16'(old + 16'd1)) begin
        chk("R6 last count", old, 4);
        chk("R6 reload", count_o, 16'hFFFC);
        chk("R6 flag", cycle_flag_o, 1);
        chk("R6 end level", pwm_o, 0);
        flag_seen = 1;
      end
      if (count_o == 16'd2 && old == 16'd1) chk("R5 edge level", pwm_o, 1);
      old = count_o;
    end
    chk("R6 reload seen", flag_seen, 1);

    // R10 flag sticky, then cleared by the strobe
    pwm_en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 sticky", cycle_flag_o, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R10 cleared", cycle_flag_o, 0);

    // R10 set wins over a clear held high
    setup(2'b00, 16'd1, 16'd4, 1'b1, 1'b0);
    do_reset();
    flag_clr = 1'b1;
    old = count_o; flag_seen = 0;
    for (int i = 0; i < 40 && flag_seen == 0; i++) begin
      @(negedge clk);
      if (count_o == 16'hFFFC && old == 16'd4) begin
        chk("R10 set wins", cycle_flag_o, 1);
        @(negedge clk);
        chk("R10 clear after set", cycle_flag_o, 0);
        flag_seen = 1;
      end
      old = count_o;
    end
    chk("R10 overlap seen", flag_seen, 1);
    flag_clr = 1'b0;

    // R8 equal levels
    setup(2'b00, 16'd2, 16'd5, 1'b1, 1'b1);
    do_reset();
    watch_pin(200, r, f);
    chk("R8 high rises", r, 1);
    chk("R8 high falls", f, 0);
    setup(2'b00, 16'd2, 16'd5, 1'b0, 1'b0);
    do_reset();
    watch_pin(200, r, f);
    chk("R8 low rises", r, 0);

    // R9 both compare values equal: end level wins
    setup(2'b00, 16'd5, 16'd5, 1'b1, 1'b0);
    do_reset();
    watch_pin(200, r, f);
    chk("R9 end low wins", r, 0);
    setup(2'b00, 16'd5, 16'd5, 1'b0, 1'b1);
    do_reset();
    watch_pin(200, r, f);
    chk("R9 end high wins rises", r, 1);
    chk("R9 end high wins falls", f, 0);

    // R11 compare values changed while running
    setup(2'b00, 16'd2, 16'd5, 1'b1, 1'b0);
    do_reset();
    measure(hi, per);
    chk("R11 before", per, 10 * 2);
    cmp_end = 16'd9;
    measure(hi, per);
    measure(hi, per);
    chk("R11 new period", per, 14 * 2);
    chk("R11 new high", hi, 7 * 2);
    cmp_edge = 16'd6;
    measure(hi, per);
    measure(hi, per);
    chk("R11 new edge high", hi, 3 * 2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    errs++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule